// File: doc/BRIEF.md
# Reference Clock Switch Sequencer

This controller sits between user logic and a clock-synthesis loop. When user logic asks for a different reference source, the controller does not pass the new 2-bit selection straight through. First it pulls the loop's active-low hold line low. It then changes the selection while the hold is active and waits for a strobe that says the new source is steady. The hold is released only after a minimum number of hold cycles has also passed. Finally the controller waits for the loop to report lock again. If lock does not come within a programmable window, a sticky error flag is raised. A request that arrives while a switch is already running is stored and is started once that switch is over.

The lock indication coming from the loop has no clock relationship with the controller and can glitch. The controller passes it through two synchronizing flops and then a run-length filter. The filtered level is the lock status that user logic sees. When the filtered lock drops while no switch is running, the controller emits a one-cycle lock-lost event.

Top module: `refclk_switch_seq`

## Requirements
- R1: After the synchronous active-high reset, `synth_hold_n` is 1 and `ref_sel` equals `INIT_SEL` (default 0). `busy`, `lock_err`, `lock_ok` and `lock_lost` are all 0.
- R2: `ref_sel` changes value only in cycles where `synth_hold_n` is 0, including the cycle just before the change.
- R3: Every low period of `synth_hold_n` lasts at least `MIN_RST_CYC` clock cycles.
- R4: A switch releases `synth_hold_n` only after `src_stable` has been sampled high following the change of `ref_sel`. If the strobe comes late, the low period stretches to cover it.
- R5: `lock_ok` follows `lock_async` only after the value from the two-flop synchronizer has differed from `lock_ok` for `DEB_CYC` consecutive cycles. A shorter glitch leaves `lock_ok` unchanged.
- R6: A fall of `lock_ok` while no switch is running produces a `lock_lost` pulse that is exactly one cycle wide.
- R7: `busy` rises in the cycle after a request is accepted. It stays high until the switch ends. The switch ends when `lock_ok` is seen high after having been seen low during the switch, or when the switch times out. A switch that ends without error ends with `lock_ok` high.
- R8: A request made while `busy` is high is queued. Only the latest such request is kept. That request starts after the running switch ends, and its selection is the one finally driven on `ref_sel`.
- R9: If lock is not seen within `LOCK_TMO` cycles after the hold is released, the switch ends and `lock_err` becomes 1. `lock_err` then stays 1 until the next accepted request clears it.
- R10: No `lock_lost` pulse is emitted while a switch is running, even though the loss of lock caused by the hold is filtered through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | One-cycle request to switch to `req_sel` |
| req_sel | input | 2 | Requested reference source |
| src_stable | input | 1 | Strobe: the selected source is steady |
| lock_async | input | 1 | Raw lock indication from the loop, unsynchronized |
| synth_hold_n | output | 1 | Hold line to the loop; 0 holds the loop, 1 lets it run |
| ref_sel | output | 2 | Reference source selection driven to the loop |
| lock_ok | output | 1 | Synchronized and filtered lock status |
| lock_lost | output | 1 | One-cycle event when lock drops outside a switch |
| busy | output | 1 | High while a switch is in progress |
| lock_err | output | 1 | Sticky flag: lock was not seen within the timeout |

## Verification
Some rules are checked by the assertions on every cycle:
- the selection never moves while the hold line is high;
- every hold pulse reaches the minimum length;
- the lost event is a single cycle and never appears while busy;
- a switch ends only with lock or with the error flag set;
- `lock_ok` moves only to the level the synchronizer holds.

The scenarios have to show the rest:
- the release waits for a late stable strobe;
- a short glitch on the raw lock is filtered out while a long drop gets through;
- a queued request keeps only its latest selection;
- the error flag stays set and is cleared by the next request.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    typedef logic [1:0] sel_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASSERT_RST,
        ST_SWITCH,
        ST_WAIT_STABLE,
        ST_RELEASE,
        ST_WAIT_LOCK
    } seq_state_t;

    typedef struct packed {
        logic vld;
        sel_t sel;
    } sel_req_t;

    // States in which the loop is held
    function automatic logic holds_loop(seq_state_t s);
        return (s == ST_ASSERT_RST) || (s == ST_SWITCH) || (s == ST_WAIT_STABLE);
    endfunction

endpackage

// File: rtl/rcs_lock_filter.sv
module rcs_lock_filter
    import rcs_pkg::*;
#(
    parameter int DEB_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_async,
    output logic lock_ok
);
    localparam int DW = $clog2(DEB_CYC + 1);
    localparam logic [DW-1:0] RUN_LAST = DW'(DEB_CYC - 1);

    logic          sync_a, sync_b;
    logic [DW-1:0] run_cnt;
    logic          lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a  <= 1'b0;
            sync_b  <= 1'b0;
            run_cnt <= '0;
            lvl_q   <= 1'b0;
        end else begin
            sync_a <= lock_async;
            sync_b <= sync_a;
            if (sync_b != lvl_q) begin
                if (run_cnt == RUN_LAST) begin
                    lvl_q   <= sync_b;
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end

    assign lock_ok = lvl_q;

    // R5: the filtered level only moves to the synchronized level
    assert_filter_follows_sync_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(lvl_q) |-> (lvl_q == $past(sync_b)));

endmodule

// File: rtl/rcs_req_queue.sv
module rcs_req_queue
    import rcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  sel_t     req_sel,
    input  logic     idle,
    output sel_req_t grant
);
    sel_req_t pend_q;

    always_comb begin
        grant.vld = idle && (pend_q.vld || req_valid);
        grant.sel = pend_q.vld ? pend_q.sel : req_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (idle && pend_q.vld) begin
            pend_q.vld <= req_valid;
            pend_q.sel <= req_sel;
        end else if (!idle && req_valid) begin
            pend_q.vld <= 1'b1;
            pend_q.sel <= req_sel;
        end
    end

    // R8: a stored request is served at the first idle cycle
    assert_queue_served_R8: assert property (@(posedge clk) disable iff (rst)
        (idle && pend_q.vld) |=> !idle);

endmodule

// File: rtl/rcs_seq_fsm.sv
module rcs_seq_fsm
    import rcs_pkg::*;
#(
    parameter int   MIN_RST_CYC = 4,
    parameter int   LOCK_TMO    = 1024,
    parameter sel_t INIT_SEL    = 2'd0
) (
    input  logic     clk,
    input  logic     rst,
    input  sel_req_t grant,
    input  logic     src_stable,
    input  logic     lock_ok,
    output logic     idle,
    output logic     synth_hold_n,
    output sel_t     ref_sel,
    output logic     busy,
    output logic     lock_err
);
    localparam int HW = $clog2(MIN_RST_CYC + 1);
    localparam int TW = $clog2(LOCK_TMO + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(MIN_RST_CYC - 1);
    localparam logic [TW-1:0] TMO_LAST  = TW'(LOCK_TMO - 1);

    seq_state_t    state, state_nx;
    logic [HW-1:0] hold_cnt;
    logic [TW-1:0] tmo_cnt;
    logic          stb_seen, saw_low, err_q;
    sel_t          sel_q, tgt_q;
    logic          stable_now, locked_now, tmo_hit;

    assign stable_now = stb_seen || src_stable;
    assign locked_now = saw_low && lock_ok;
    assign tmo_hit    = (tmo_cnt == TMO_LAST);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:        if (grant.vld) state_nx = ST_ASSERT_RST;
            ST_ASSERT_RST:  state_nx = ST_SWITCH;
            ST_SWITCH:      state_nx = ST_WAIT_STABLE;
            ST_WAIT_STABLE: if (stable_now && hold_cnt >= HOLD_LAST) state_nx = ST_RELEASE;
            ST_RELEASE:     state_nx = ST_WAIT_LOCK;
            ST_WAIT_LOCK:   if (locked_now || tmo_hit) state_nx = ST_IDLE;
            default:        state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            hold_cnt <= '0;
            tmo_cnt  <= '0;
            stb_seen <= 1'b0;
            saw_low  <= 1'b0;
            err_q    <= 1'b0;
            sel_q    <= INIT_SEL;
            tgt_q    <= INIT_SEL;
        end else begin
            state <= state_nx;

            if (holds_loop(state)) begin
                if (hold_cnt < HOLD_LAST) hold_cnt <= hold_cnt + 1'b1;
            end else begin
                hold_cnt <= '0;
            end

            if (state == ST_WAIT_LOCK) tmo_cnt <= tmo_cnt + 1'b1;
            else                       tmo_cnt <= '0;

            if (state == ST_WAIT_STABLE && src_stable) stb_seen <= 1'b1;
            else if (state == ST_IDLE)                 stb_seen <= 1'b0;

            if (state == ST_IDLE)  saw_low <= 1'b0;
            else if (!lock_ok)     saw_low <= 1'b1;

            if (state == ST_IDLE && grant.vld) begin
                tgt_q <= grant.sel;
                err_q <= 1'b0;
            end
            if (state == ST_SWITCH) sel_q <= tgt_q;
            if (state == ST_WAIT_LOCK && !locked_now && tmo_hit) err_q <= 1'b1;
        end
    end

    assign idle         = (state == ST_IDLE);
    assign synth_hold_n = !holds_loop(state);
    assign ref_sel      = sel_q;
    assign busy         = !idle;
    assign lock_err     = err_q;

    // R2: selection frozen while the loop runs
    assert_sel_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        synth_hold_n |-> $stable(sel_q));

    // R7: a switch ends with lock or with the error flag
    assert_end_locked_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (lock_ok || err_q));

    // R9: the error flag rises only at the end of a lock wait
    assert_err_from_wait_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> ($past(state) == ST_WAIT_LOCK));

endmodule

// File: rtl/refclk_switch_seq.sv
module refclk_switch_seq
    import rcs_pkg::*;
#(
    parameter int   MIN_RST_CYC = 4,
    parameter int   DEB_CYC     = 4,
    parameter int   LOCK_TMO    = 1024,
    parameter sel_t INIT_SEL    = 2'd0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] req_sel,
    input  logic       src_stable,
    input  logic       lock_async,
    output logic       synth_hold_n,
    output logic [1:0] ref_sel,
    output logic       lock_ok,
    output logic       lock_lost,
    output logic       busy,
    output logic       lock_err
);
    localparam int LW = $clog2(MIN_RST_CYC + 2);
    localparam logic [LW-1:0] LOW_MIN = LW'(MIN_RST_CYC);

    sel_req_t grant;
    logic     idle;
    logic     lock_ok_d;

    rcs_lock_filter #(.DEB_CYC(DEB_CYC)) u_filt (
        .clk        (clk),
        .rst        (rst),
        .lock_async (lock_async),
        .lock_ok    (lock_ok)
    );

    rcs_req_queue u_queue (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_sel   (req_sel),
        .idle      (idle),
        .grant     (grant)
    );

    rcs_seq_fsm #(
        .MIN_RST_CYC (MIN_RST_CYC),
        .LOCK_TMO    (LOCK_TMO),
        .INIT_SEL    (INIT_SEL)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .grant        (grant),
        .src_stable   (src_stable),
        .lock_ok      (lock_ok),
        .idle         (idle),
        .synth_hold_n (synth_hold_n),
        .ref_sel      (ref_sel),
        .busy         (busy),
        .lock_err     (lock_err)
    );

    always_ff @(posedge clk) begin
        if (rst) lock_ok_d <= 1'b0;
        else     lock_ok_d <= lock_ok;
    end

    assign lock_lost = lock_ok_d && !lock_ok && idle;

    // Checker: length of the current low run of the hold line
    logic [LW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (rst)                   low_run <= '0;
        else if (synth_hold_n)     low_run <= '0;
        else if (low_run < LOW_MIN) low_run <= low_run + 1'b1;
    end

    // R3: minimum hold pulse length
    assert_min_hold_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(synth_hold_n) |-> (low_run >= LOW_MIN));

    // R6: lost event is a single cycle
    assert_lost_single_R6: assert property (@(posedge clk) disable iff (rst)
        lock_lost |=> !lock_lost);

    // R10: no lost event during a switch
    assert_lost_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
        lock_lost |-> !busy);

endmodule

// File: tb/sim_refclk_switch_seq.sv
module sim_refclk_switch_seq;

    localparam int MIN_RST = 8;
    localparam int DEB     = 4;
    localparam int TMO     = 40;
    localparam int LOCK_DLY = 10;

    typedef struct packed {
        logic [1:0] sel;
        logic       err;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_sel = 2'd0;
    logic       src_stable = 1'b0;
    logic       lock_async = 1'b0;
    logic       synth_hold_n, lock_ok, lock_lost, busy, lock_err;
    logic [1:0] ref_sel;

    always #10 clk = ~clk;

    refclk_switch_seq #(
        .MIN_RST_CYC (MIN_RST),
        .DEB_CYC     (DEB),
        .LOCK_TMO    (TMO),
        .INIT_SEL    (2'd0)
    ) u0 (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_sel      (req_sel),
        .src_stable   (src_stable),
        .lock_async   (lock_async),
        .synth_hold_n (synth_hold_n),
        .ref_sel      (ref_sel),
        .lock_ok      (lock_ok),
        .lock_lost    (lock_lost),
        .busy         (busy),
        .lock_err     (lock_err)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t sb[$];
    bit   done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Loop model controls (written by the stimulus only)
    int stb_dly  = 3;
    bit pll_dead = 0;
    int drop_len = 0;
    int drop_seq = 0;

    // Loop model state (written by the model only)
    int lo_cnt = 0, hi_cnt = 0, drop_left = 0, drop_seen = 0;
    bit stb_in_low = 0;

    always @(negedge clk) begin
        if (rst) begin
            lo_cnt = 0; hi_cnt = 0; drop_left = 0;
            lock_async = 0; src_stable = 0; stb_in_low = 0;
        end else begin
            src_stable = 0;
            if (drop_seq != drop_seen) begin
                drop_seen = drop_seq;
                drop_left = drop_len;
            end
            if (!synth_hold_n) begin
                hi_cnt = 0;
                if (lo_cnt == 0) stb_in_low = 0;
                lo_cnt++;
                lock_async = 0;
                if (lo_cnt == stb_dly) begin
                    src_stable = 1;
                    stb_in_low = 1;
                end
            end else begin
                lo_cnt = 0;
                if (hi_cnt < LOCK_DLY) hi_cnt++;
                if (drop_left > 0) begin
                    drop_left--;
                    lock_async = 0;
                end else begin
                    lock_async = !pll_dead && (hi_cnt >= LOCK_DLY);
                end
            end
        end
    end

    // Monitor and scoreboard
    int   low_w = 0;
    int   lost_cnt = 0;
    bit   busy_p = 0, lost_p = 0;
    logic [1:0] sel_p = 2'd0;
    exp_t got;

    always @(negedge clk) begin
        if (!rst) begin
            if (ref_sel != sel_p)
                chk(!synth_hold_n, "R2 sel moved with hold released", ref_sel, sel_p);
            if (!synth_hold_n) begin
                low_w++;
            end else if (low_w > 0) begin
                chk(low_w >= MIN_RST, "R3 hold width", low_w, MIN_RST);
                chk(stb_in_low && low_w >= stb_dly, "R4 release after stable", low_w, stb_dly);
                low_w = 0;
            end
            if (lock_lost) lost_cnt++;
            if (lock_lost && lost_p) chk(0, "R6 lost pulse width", 2, 1);
            if (busy_p && !busy) begin
                if (sb.size() == 0) begin
                    chk(0, "R8 unexpected switch end", 1, 0);
                end else begin
                    got = sb.pop_front();
                    chk(ref_sel == got.sel, "R8 final selection", ref_sel, got.sel);
                    chk(lock_err == got.err, "R9 error at end", lock_err, got.err);
                    if (!got.err) chk(lock_ok, "R7 locked at end", lock_ok, 1);
                end
            end
            busy_p = busy;
            lost_p = lock_lost;
            sel_p  = ref_sel;
        end
    end

    task automatic do_switch(input logic [1:0] s, input bit push, input bit e);
        exp_t x;
        @(negedge clk);
        req_valid = 1; req_sel = s;
        if (push) begin
            x.sel = s; x.err = e;
            sb.push_back(x);
        end
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (sb.size() == 0 && !busy) break;
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    int lost0;

    initial begin
        wait_cyc(5);
        rst = 0;
        @(negedge clk);
        chk(synth_hold_n == 1, "R1 hold line", synth_hold_n, 1);
        chk(ref_sel == 2'd0, "R1 selection", ref_sel, 0);
        chk(busy == 0 && lock_err == 0, "R1 busy/err", {busy, lock_err}, 0);
        chk(lock_ok == 0 && lock_lost == 0, "R1 lock outputs", {lock_ok, lock_lost}, 0);

        wait_cyc(40);
        chk(lock_ok == 1, "R5 lock accepted", lock_ok, 1);
        lost0 = lost_cnt;

        // early strobe: minimum width governs
        stb_dly = 3;
        do_switch(2'd2, 1, 0);
        wait_cyc(2);
        chk(busy == 1, "R7 busy during switch", busy, 1);
        wait_idle();

        // late strobe: hold stretches
        stb_dly = 15;
        do_switch(2'd1, 1, 0);
        wait_idle();
        chk(ref_sel == 2'd1, "R4 late strobe selection", ref_sel, 1);

        // queued requests, latest wins
        stb_dly = 3;
        do_switch(2'd3, 1, 0);
        wait_cyc(4);
        do_switch(2'd0, 0, 0);
        wait_cyc(2);
        do_switch(2'd1, 1, 0);
        wait_idle();
        wait_cyc(3);
        chk(ref_sel == 2'd1 && !busy, "R8 queued latest applied", ref_sel, 1);
        chk(lost_cnt == lost0, "R10 no lost during switches", lost_cnt, lost0);

        // short glitch is filtered
        wait_cyc(5);
        drop_len = 2; drop_seq++;
        wait_cyc(20);
        chk(lock_ok == 1, "R5 glitch ignored", lock_ok, 1);
        chk(lost_cnt == lost0, "R5 glitch no lost event", lost_cnt, lost0);

        // real loss in idle
        drop_len = 30; drop_seq++;
        wait_cyc(12);
        chk(lock_ok == 0, "R5 long drop accepted", lock_ok, 0);
        chk(lost_cnt == lost0 + 1, "R6 lost event count", lost_cnt, lost0 + 1);
        wait_cyc(40);
        chk(lock_ok == 1, "R5 relock", lock_ok, 1);

        // timeout
        pll_dead = 1;
        do_switch(2'd2, 1, 1);
        wait_idle();
        wait_cyc(10);
        chk(lock_err == 1, "R9 error sticky", lock_err, 1);
        pll_dead = 0;
        do_switch(2'd3, 1, 0);
        chk(lock_err == 0, "R9 error cleared by request", lock_err, 0);
        wait_idle();
        chk(ref_sel == 2'd3 && lock_ok, "R7 recovered after error", ref_sel, 3);
        chk(sb.size() == 0, "R8 scoreboard drained", sb.size(), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule